// File: doc/BRIEF.md
# Register-Mapped SPI Master with Word FIFOs

This block is a serial peripheral interface master that software drives through a 32-bit register port. Words written to the transmit data register queue in a transmit FIFO. Each received word lands in a receive FIFO, and a read of the receive data register pops it. The serial clock rate is a fixed build parameter. Software cannot change it.

A transmit-hold bit in the control register lets software fill the queue while nothing moves. Clearing the bit sends every queued word back to back until the queue is empty. Clock polarity, clock phase, bit order and an internal loopback path are set in the control register.

Select lines can follow a software register directly, or they can be driven from that register only while a word shifts. A small interrupt unit collects events in write-one-to-clear status bits. These bits pass through an enable mask and a global gate. A write of a fixed key value to the reset register restores every register and both FIFOs to their reset state.

Top module: `spi_host_top`

## Requirements
- R1: After reset, the status register (0x64) reads 0x05, which is bit0 RX empty plus bit2 TX empty; bit1 is RX full, bit3 is TX full and bit4 is mode fault. The control register (0x60) reads 0, the select register (0x70) reads all ones, `ss_n` is all ones, `irq` is 0 and `sclk` is 0.
- R2: While control bit8 (transmit hold) is 1, no word leaves the TX FIFO and `sclk` does not toggle. Once bit8 is 0 and bit1 (enable) and bit2 (master) are both 1, every queued word is shifted back to back until the TX FIFO is empty.
- R3: TX full (status bit3) becomes 1 after exactly DEPTH words are pushed through 0x68 without draining. A push to a full TX FIFO is dropped and sets interrupt status bit3.
- R4: With control bit0 (loopback) set, each shifted word comes back unchanged in the RX FIFO in all four clock modes and in both bit orders, and `miso` is ignored.
- R5: When idle, `sclk` rests at control bit3 (CPOL). MOSI is valid on the sampling edge, which is the rising edge when CPOL equals control bit4 (CPHA) and the falling edge otherwise. Bits go out MSB first, or LSB first when control bit9 is 1.
- R6: Without loopback, the bits sampled from `miso` form the received word.
- R7: A read of 0x6C pops the RX FIFO. A read of an empty RX FIFO returns 0 and leaves the status unchanged. RX full (status bit1) is set when DEPTH words are held. A word that arrives while the RX FIFO is full is dropped and sets interrupt status bit5.
- R8: With control bit7 (manual select) set, `ss_n` equals the select register. Otherwise `ss_n` equals the select register only while a word shifts, and is all ones at other times.
- R9: Interrupt status (0x20) bits clear when 1 is written to them. `irq` is 1 only when bit31 of 0x1C is 1 and a status bit whose enable bit in 0x28 is 1 is pending.
- R10: Interrupt status bit2 is set when a word completes with the TX FIFO empty. Bit6 is set when the TX count falls to DEPTH/2. Bit4 is set when the RX FIFO becomes full.
- R11: Control bit5 and bit6 flush the TX and RX FIFO, respectively, on the write that sets them. Both bits always read back as 0.
- R12: Writing 0x0000000A to 0x40 restores every register and both FIFOs to their reset values. Writing any other value there has no effect.
- R13: While enable and master are set, a low `fault_n` sets status bit4 and interrupt status bit0. Status bit4 stays set until the status register is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RX on 0x6C) |
| bus_addr | input | 7 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low select lines |
| fault_n | input | 1 | Active-low external mode-fault sense |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with 8-bit words, a FIFO depth of 4, a clock divider of 2 and four select lines. A depth of 4 makes the full, overrun and half-empty thresholds reachable within a few words. Eight-bit words let a bench monitor on `sclk` rebuild every MOSI word in all four modes and both bit orders. A divider of 2 keeps each word at 32 cycles, so a full queue drains and overruns the RX FIFO within a few hundred cycles.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
    localparam logic [6:0] A_GIE  = 7'h1C;
    localparam logic [6:0] A_ISR  = 7'h20;
    localparam logic [6:0] A_IER  = 7'h28;
    localparam logic [6:0] A_SRST = 7'h40;
    localparam logic [6:0] A_CTL  = 7'h60;
    localparam logic [6:0] A_STAT = 7'h64;
    localparam logic [6:0] A_TXD  = 7'h68;
    localparam logic [6:0] A_RXD  = 7'h6C;
    localparam logic [6:0] A_SEL  = 7'h70;

    localparam int C_LOOP  = 0;
    localparam int C_EN    = 1;
    localparam int C_MAST  = 2;
    localparam int C_CPOL  = 3;
    localparam int C_CPHA  = 4;
    localparam int C_TXCLR = 5;
    localparam int C_RXCLR = 6;
    localparam int C_MAN   = 7;
    localparam int C_HOLD  = 8;
    localparam int C_LSB   = 9;

    localparam int I_MFLT  = 0;
    localparam int I_TXE   = 2;
    localparam int I_TXDRP = 3;
    localparam int I_RXF   = 4;
    localparam int I_RXOVR = 5;
    localparam int I_TXH   = 6;

    localparam logic [31:0] SRST_KEY = 32'h0000_000A;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    logic [W-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    always_comb begin
        st_d    = st_q;
        push_ok = push && !flush && (st_q.cnt != CW'(DEPTH));
        pop_ok  = pop && !flush && (st_q.cnt != '0);
        if (push_ok) st_d.wr = (st_q.wr == PW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        if (pop_ok)  st_d.rd = (st_q.rd == PW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        st_d.cnt = st_q.cnt + CW'(push_ok) - CW'(pop_ok);
        if (flush) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wr] <= din;
    end

    assign dout  = mem_q[st_q.rd];
    assign count = st_q.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH)); // R3
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop && !flush && st_q.cnt == CW'(DEPTH) |=> st_q.cnt == CW'(DEPTH)); // R3
    AST_EMPTY_POP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !push && !flush && st_q.cnt == '0 |=> st_q.cnt == '0); // R7
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int W       = 8,
    parameter int CLK_DIV = 2,
    localparam int HW     = $clog2(2 * W),
    localparam int DW     = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         lsb,
    input  logic         loop,
    input  logic         start,
    input  logic [W-1:0] word_in,
    input  logic         miso,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] word_out,
    output logic         sclk,
    output logic         mosi
);
    typedef struct packed {
        logic          busy;
        logic          ph;
        logic [HW-1:0] hcnt;
        logic [DW-1:0] div;
        logic [W-1:0]  txsh;
        logic [W-1:0]  rxsh;
        logic          mo;
    } eng_st_t;

    eng_st_t e_q, e_d;
    logic [W-1:0] load_w;
    logic         sample_edge;
    logic         din;

    function automatic logic [W-1:0] flip(input logic [W-1:0] v);
        for (int i = 0; i < W; i++) flip[i] = v[W-1-i];
    endfunction

    always_comb begin
        e_d         = e_q;
        done        = 1'b0;
        load_w      = lsb ? flip(word_in) : word_in;
        din         = loop ? e_q.mo : miso;
        sample_edge = (e_q.hcnt[0] == 1'b0) ^ cpha;
        if (clr) begin
            e_d = '0;
        end else if (!e_q.busy) begin
            if (start) begin
                e_d.busy = 1'b1;
                e_d.ph   = 1'b0;
                e_d.hcnt = '0;
                e_d.div  = '0;
                e_d.txsh = load_w;
                if (!cpha) begin
                    e_d.mo   = load_w[W-1];
                    e_d.txsh = load_w << 1;
                end
            end
        end else if (e_q.div == DW'(CLK_DIV - 1)) begin
            e_d.div  = '0;
            e_d.ph   = !e_q.ph;
            e_d.hcnt = e_q.hcnt + 1'b1;
            if (sample_edge) begin
                e_d.rxsh = {e_q.rxsh[W-2:0], din};
            end else begin
                e_d.mo   = e_q.txsh[W-1];
                e_d.txsh = e_q.txsh << 1;
            end
            if (e_q.hcnt == HW'(2 * W - 1)) begin
                e_d.busy = 1'b0;
                done     = 1'b1;
            end
        end else begin
            e_d.div = e_q.div + 1'b1;
        end
        word_out = lsb ? flip(e_d.rxsh) : e_d.rxsh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign busy = e_q.busy;
    assign sclk = e_q.ph ^ cpol;
    assign mosi = e_q.mo;

    AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !e_q.busy |-> !e_q.ph); // R5
endmodule

// File: rtl/spi_host_top.sv
module spi_host_top
    import spi_host_pkg::*;
#(
    parameter int W       = 8,
    parameter int DEPTH   = 4,
    parameter int CLK_DIV = 2,
    parameter int NUM_SS  = 4,
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int HALF   = DEPTH / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [6:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_SS-1:0] ss_n,
    input  logic              fault_n,
    output logic              irq
);
    typedef struct packed {
        logic [9:0]        ctl;
        logic [NUM_SS-1:0] sel;
        logic              gie;
        logic [6:0]        isr;
        logic [6:0]        ier;
        logic              mf;
    } regs_t;

    localparam regs_t RST = '{ctl: '0, sel: '1, gie: 1'b0, isr: '0, ier: '0, mf: 1'b0};

    regs_t r_q, r_d;
    logic srst, tx_flush, rx_flush, go, eng_busy, eng_done;
    logic tx_push, rx_pop, tx_push_ok, rx_pop_ok, rx_push_ok, tx_pop_ok;
    logic [CW-1:0] tx_cnt, rx_cnt, tx_nx, rx_nx;
    logic [W-1:0]  tx_dout, rx_dout, rx_word;
    logic [6:0]    ev;

    always_comb begin
        r_d      = r_q;
        srst     = bus_wr && bus_addr == A_SRST && bus_wdata == SRST_KEY;
        tx_flush = srst || (bus_wr && bus_addr == A_CTL && bus_wdata[C_TXCLR]);
        rx_flush = srst || (bus_wr && bus_addr == A_CTL && bus_wdata[C_RXCLR]);
        tx_push  = bus_wr && bus_addr == A_TXD;
        rx_pop   = bus_rd && bus_addr == A_RXD;
        go       = r_q.ctl[C_EN] && r_q.ctl[C_MAST] && !r_q.ctl[C_HOLD]
                   && tx_cnt != '0 && !eng_busy && !srst;

        tx_push_ok = tx_push && tx_cnt != CW'(DEPTH);
        tx_pop_ok  = go;
        rx_push_ok = eng_done && rx_cnt != CW'(DEPTH);
        rx_pop_ok  = rx_pop && rx_cnt != '0;
        tx_nx = tx_cnt + CW'(tx_push_ok) - CW'(tx_pop_ok);
        rx_nx = rx_cnt + CW'(rx_push_ok) - CW'(rx_pop_ok);

        ev          = '0;
        ev[I_MFLT]  = r_q.ctl[C_EN] && r_q.ctl[C_MAST] && !fault_n;
        ev[I_TXE]   = eng_done && tx_cnt == '0;
        ev[I_TXDRP] = tx_push && !tx_push_ok;
        ev[I_RXF]   = rx_cnt != CW'(DEPTH) && rx_nx == CW'(DEPTH);
        ev[I_RXOVR] = eng_done && !rx_push_ok;
        ev[I_TXH]   = tx_cnt > CW'(HALF) && tx_nx == CW'(HALF);

        if (bus_wr) begin
            case (bus_addr)
                A_CTL: r_d.ctl = bus_wdata[9:0] & ~(10'b1 << C_TXCLR) & ~(10'b1 << C_RXCLR);
                A_SEL: r_d.sel = bus_wdata[NUM_SS-1:0];
                A_GIE: r_d.gie = bus_wdata[31];
                A_IER: r_d.ier = bus_wdata[6:0];
                A_ISR: r_d.isr = r_q.isr & ~bus_wdata[6:0];
                default: ;
            endcase
        end
        if (bus_rd && bus_addr == A_STAT) r_d.mf = 1'b0;
        if (ev[I_MFLT]) r_d.mf = 1'b1;
        r_d.isr = r_d.isr | ev;
        if (srst) r_d = RST;

        bus_rdata = '0;
        case (bus_addr)
            A_CTL:  bus_rdata[9:0] = r_q.ctl;
            A_STAT: bus_rdata[4:0] = {r_q.mf, tx_cnt == CW'(DEPTH), tx_cnt == '0,
                                      rx_cnt == CW'(DEPTH), rx_cnt == '0};
            A_RXD:  bus_rdata[W-1:0] = (rx_cnt != '0) ? rx_dout : '0;
            A_SEL:  bus_rdata[NUM_SS-1:0] = r_q.sel;
            A_GIE:  bus_rdata[31] = r_q.gie;
            A_ISR:  bus_rdata[6:0] = r_q.isr;
            A_IER:  bus_rdata[6:0] = r_q.ier;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST;
        else        r_q <= r_d;
    end

    assign irq  = r_q.gie && |(r_q.isr & r_q.ier);
    assign ss_n = (r_q.ctl[C_MAN] || eng_busy) ? r_q.sel : '1;

    spi_word_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_push),
        .din(bus_wdata[W-1:0]), .pop(tx_pop_ok), .dout(tx_dout), .count(tx_cnt));

    spi_word_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(eng_done),
        .din(rx_word), .pop(rx_pop), .dout(rx_dout), .count(rx_cnt));

    spi_shift_engine #(.W(W), .CLK_DIV(CLK_DIV)) u_eng (
        .clk(clk), .rst_n(rst_n), .clr(srst), .cpol(r_q.ctl[C_CPOL]),
        .cpha(r_q.ctl[C_CPHA]), .lsb(r_q.ctl[C_LSB]), .loop(r_q.ctl[C_LOOP]),
        .start(go), .word_in(tx_dout), .miso(miso), .busy(eng_busy),
        .done(eng_done), .word_out(rx_word), .sclk(sclk), .mosi(mosi));

    AST_HOLD_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ctl[C_HOLD] && !eng_busy |=> !eng_busy); // R2
    AST_SRST_CLEARS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> r_q.ctl == '0 && !eng_busy); // R12
endmodule

// File: tb/spi_host_top_tb_top.sv
module spi_host_top_tb_top;
    import spi_host_pkg::*;

    logic clk = 0, rst_n = 0;
    logic bus_wr = 0, bus_rd = 0, miso = 0, fault_n = 1;
    logic [6:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic sclk, mosi, irq;
    logic [3:0] ss_n;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic m_cpol = 0, m_cpha = 0, mon_on = 0;
    logic [7:0] mon_sh;
    int mon_bits = 0, mon_n = 0;
    logic [7:0] mon_w [4];

    always #4 clk = !clk;

    spi_host_top #(.W(8), .DEPTH(4), .CLK_DIV(2), .NUM_SS(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n),
        .fault_n(fault_n), .irq(irq));

    task automatic cap_bit();
        mon_sh = {mon_sh[6:0], mosi};
        mon_bits++;
        if (mon_bits == 8) begin
            if (mon_n < 4) mon_w[mon_n] = mon_sh;
            mon_n++;
            mon_bits = 0;
        end
    endtask

    always @(posedge sclk) if (mon_on && m_cpol == m_cpha) cap_bit();
    always @(negedge sclk) if (mon_on && m_cpol != m_cpha) cap_bit();

    function automatic logic [7:0] rev8(input logic [7:0] v);
        for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
    endfunction

    function automatic logic [31:0] mk_ctl(input logic loop, cpol, cpha, lsb, hold, man);
        mk_ctl = 32'h6 | 32'(loop) | (32'(cpol) << 3) | (32'(cpha) << 4)
               | (32'(man) << 7) | (32'(hold) << 8) | (32'(lsb) << 9);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        logic [7:0] w [3];
        int pushed;
        void'($urandom(32'd7));
        idle(3);
        rst_n = 1;
        idle(2);
        // R1 reset state
        rd(A_STAT, d); chk("R1 status", d, 32'h05);
        rd(A_CTL, d);  chk("R1 ctl", d, 0);
        rd(A_SEL, d);  chk("R1 sel", d, 32'hF);
        chk("R1 ss_n", 32'(ss_n), 32'hF);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 sclk", 32'(sclk), 0);

        // R3 depth discovery under hold
        wr(A_CTL, mk_ctl(0, 0, 0, 0, 1, 0));
        pushed = 0;
        for (int k = 0; k < 8; k++) begin
            wr(A_TXD, 32'(k));
            pushed++;
            rd(A_STAT, d);
            if (d[3]) break;
        end
        chk("R3 full after DEPTH pushes", 32'(pushed), 4);
        wr(A_TXD, 32'h99);
        rd(A_ISR, d); chk("R3 drop flag", 32'(d[3]), 1);
        idle(100);
        rd(A_STAT, d); chk("R2 hold keeps TX", d, 32'h09);
        chk("R2 sclk quiet", 32'(sclk), 0);

        // R11 flush
        wr(A_CTL, mk_ctl(0, 0, 0, 0, 1, 0) | 32'h20);
        rd(A_STAT, d); chk("R11 TX flushed", d, 32'h05);
        rd(A_CTL, d);  chk("R11 self-clear", d, mk_ctl(0, 0, 0, 0, 1, 0));

        // R4 / R5 loopback sweep, miso held opposite
        miso = 1;
        for (int md = 0; md < 8; md++) begin
            logic cp, ch, lb;
            cp = md[0]; ch = md[1]; lb = md[2];
            wr(A_CTL, mk_ctl(1, cp, ch, lb, 1, 0));
            m_cpol = cp; m_cpha = ch;
            idle(2);
            mon_bits = 0; mon_n = 0; mon_on = 1;
            chk("R5 idle level", 32'(sclk), 32'(cp));
            for (int k = 0; k < 3; k++) begin
                w[k] = 8'($urandom);
                if (k == 0) w[k] = 8'h01;
                wr(A_TXD, 32'(w[k]));
            end
            wr(A_CTL, mk_ctl(1, cp, ch, lb, 0, 0));
            idle(150);
            mon_on = 0;
            for (int k = 0; k < 3; k++) begin
                rd(A_RXD, d); chk("R4 loopback echo", d, 32'(w[k]));
                chk("R5 mosi order", 32'(mon_w[k]), 32'(lb ? rev8(w[k]) : w[k]));
            end
            chk("R2 drained count", 32'(mon_n), 3);
        end

        // R6 external receive
        for (int v = 0; v < 2; v++) begin
            miso = v[0];
            wr(A_CTL, mk_ctl(0, 0, 0, 0, 1, 0));
            wr(A_TXD, 32'hA5);
            wr(A_CTL, mk_ctl(0, 0, 0, 0, 0, 0));
            idle(60);
            rd(A_RXD, d); chk("R6 miso capture", d, v ? 32'hFF : 32'h00);
        end

        // R7 / R10 overrun and events
        wr(A_CTL, mk_ctl(1, 0, 0, 0, 1, 0));
        wr(A_ISR, 32'h7F);
        for (int k = 1; k <= 4; k++) wr(A_TXD, 32'(k * 17));
        wr(A_CTL, mk_ctl(1, 0, 0, 0, 0, 0));
        idle(200);
        wr(A_CTL, mk_ctl(1, 0, 0, 0, 1, 0));
        wr(A_TXD, 32'h55);
        wr(A_CTL, mk_ctl(1, 0, 0, 0, 0, 0));
        idle(60);
        rd(A_STAT, d); chk("R7 RX full", d, 32'h06);
        rd(A_ISR, d);  chk("R10 R7 events", d, 32'h74);
        for (int k = 1; k <= 4; k++) begin
            rd(A_RXD, d); chk("R7 pop order", d, 32'(k * 17));
        end
        rd(A_RXD, d);  chk("R7 empty pop", d, 0);
        rd(A_STAT, d); chk("R7 empty stable", d, 32'h05);

        // R9 interrupt gating and W1C
        wr(A_IER, 32'h7F);
        chk("R9 gie off", 32'(irq), 0);
        wr(A_GIE, 32'h8000_0000);
        chk("R9 gie on", 32'(irq), 1);
        wr(A_ISR, 32'h04);
        rd(A_ISR, d); chk("R9 partial clear", d, 32'h70);
        wr(A_ISR, 32'h7F);
        chk("R9 irq drops", 32'(irq), 0);

        // R8 select modes
        wr(A_CTL, mk_ctl(0, 0, 0, 0, 1, 1));
        wr(A_SEL, 32'hA);
        chk("R8 manual", 32'(ss_n), 32'hA);
        wr(A_CTL, mk_ctl(1, 0, 0, 0, 1, 0));
        wr(A_SEL, 32'hE);
        chk("R8 auto idle", 32'(ss_n), 32'hF);
        wr(A_TXD, 32'h3C);
        wr(A_CTL, mk_ctl(1, 0, 0, 0, 0, 0));
        idle(10);
        chk("R8 auto active", 32'(ss_n), 32'hE);
        idle(60);
        chk("R8 auto release", 32'(ss_n), 32'hF);
        rd(A_RXD, d); chk("R4 echo after select", d, 32'h3C);

        // R13 mode fault
        @(negedge clk); fault_n = 0;
        idle(2); fault_n = 1;
        rd(A_STAT, d); chk("R13 fault flag", d, 32'h15);
        rd(A_ISR, d);  chk("R13 fault irq bit", d, 32'h05);
        rd(A_STAT, d); chk("R13 read clears", d, 32'h05);

        // R12 soft reset
        wr(A_SRST, 32'h0B);
        rd(A_CTL, d); chk("R12 wrong key ignored", d, 32'h07);
        wr(A_SRST, 32'h0A);
        rd(A_CTL, d);  chk("R12 ctl", d, 0);
        rd(A_SEL, d);  chk("R12 sel", d, 32'hF);
        rd(A_STAT, d); chk("R12 status", d, 32'h05);
        rd(A_ISR, d);  chk("R12 isr", d, 0);
        rd(A_GIE, d);  chk("R12 gie", d, 0);
        finish_run();
    end
endmodule